// File: doc/BRIEF.md
# Gated-Trigger Set/Reset Flip-Flop

This block stores one bit that is changed by falling edges on two groups of trigger inputs. One group sets the bit and the other clears it. Each trigger has its own active-low gate input. A falling trigger edge counts only if its gate is low in the cycle where the edge is seen. A high gate blocks that trigger. Each side has three trigger/gate pairs: two base pairs and one extender pair at index 2. Two active-high level inputs, force-set and force-clear, drive the bit directly and take priority over every trigger. The block drives the stored bit on a true output and on a complementary output.

All inputs are asynchronous to the system clock and pass through two-flop synchronizers. Falling edges are found by comparing each synchronized trigger with a one-cycle history register. The history resets to high, so no edge appears at startup.

An event decoder gives each cycle one named event, in priority order:
- `EV_FORCE_CLR`
- `EV_FORCE_SET`
- `EV_TOGGLE` (accepted edges on both sides at once)
- `EV_SET`
- `EV_CLR`
- `EV_NONE`

A two-state machine (`ST_LOW`, `ST_HIGH`) uses that event. From `ST_LOW` it moves to `ST_HIGH` on `EV_SET`, `EV_TOGGLE` or `EV_FORCE_SET`. From `ST_HIGH` it moves to `ST_LOW` on `EV_CLR`, `EV_TOGGLE` or `EV_FORCE_CLR`. Every other event keeps the state.

Top module: `gated_trigger_ff`

## Requirements
- R1: The synchronous reset `rst` (active high) gives `q`=0 and `q_n`=1. No trigger edge is seen after release while all triggers stay high.
- R2: A falling edge on `set_trig[i]` while `set_gate_n[i]` is low (0) drives `q` to 1.
- R3: A falling edge on `clr_trig[i]` while `clr_gate_n[i]` is low (0) drives `q` to 0.
- R4: A trigger edge is ignored while its gate is high (1). This includes a gate that falls one cycle after the trigger edge.
- R5: Rising edges on triggers and steady trigger levels leave `q` unchanged.
- R6: All three pairs per side act independently, including the extender pair at index 2.
- R7: Accepted set-side and clear-side edges in the same cycle invert `q`.
- R8: While `force_set`=1 (and `force_clr`=0), `q` is 1 regardless of any trigger edge.
- R9: While `force_clr`=1, `q` is 0, even with `force_set`=1 or trigger edges present.
- R10: `q_n` is always the complement of `q` outside reset.
- R11: An input change appears on `q` after the third rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| set_trig | input | PAIRS | Set-side triggers, act on falling edge |
| set_gate_n | input | PAIRS | Set-side gates, low enables the paired trigger |
| clr_trig | input | PAIRS | Clear-side triggers, act on falling edge |
| clr_gate_n | input | PAIRS | Clear-side gates, low enables the paired trigger |
| force_set | input | 1 | Direct set, active high |
| force_clr | input | 1 | Direct clear, active high, wins over force_set |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Complement of the stored bit |

## Verification
The hardest case to reach from the ports is the same-cycle collision of two accepted edges from opposite sides, which produces the toggle. The stimulus reaches it by lowering both gates and both triggers in the same clock low phase, so the two edges travel through identical synchronizer depths and meet in the same detection cycle. A second timing corner puts the gate fall one cycle after the trigger fall, to show that the gate is sampled only in the detection cycle. Force inputs are held while opposing trigger edges arrive, to show that they override the triggers.

// File: rtl/gtff_pkg.sv
package gtff_pkg;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } bit_state_e;

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_SET       = 3'd1,
        EV_CLR       = 3'd2,
        EV_TOGGLE    = 3'd3,
        EV_FORCE_SET = 3'd4,
        EV_FORCE_CLR = 3'd5
    } trig_event_e;

endpackage

// File: rtl/gtff_sync.sv
module gtff_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= {WIDTH{RST_VAL}};
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= {WIDTH{RST_VAL}};
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gtff_edge_gate.sv
module gtff_edge_gate #(
    parameter int PAIRS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAIRS-1:0] trig_s,
    input  logic [PAIRS-1:0] gate_s,
    output logic             accept
);
    logic [PAIRS-1:0] hist;
    logic [PAIRS-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) hist <= '1;
        else     hist <= trig_s;
    end

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign acc[g] = hist[g] & ~trig_s[g] & ~gate_s[g];

        // R5: an accepted edge is a one-shot; the history must follow the low level
        assert_hist_follows_R5: assert property (@(posedge clk) disable iff (rst)
            acc[g] |=> !hist[g]);
    end

    assign accept = |acc;
endmodule

// File: rtl/gated_trigger_ff.sv
module gated_trigger_ff
    import gtff_pkg::*;
#(
    parameter int PAIRS       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PAIRS-1:0] set_trig,
    input  logic [PAIRS-1:0] set_gate_n,
    input  logic [PAIRS-1:0] clr_trig,
    input  logic [PAIRS-1:0] clr_gate_n,
    input  logic             force_set,
    input  logic             force_clr,
    output logic             q,
    output logic             q_n
);
    localparam int LVL_W = 2 * PAIRS;

    logic [LVL_W-1:0] trig_s, gate_s;
    logic [1:0]       force_s;
    logic             set_acc, clr_acc;
    trig_event_e      ev;
    bit_state_e       state_q, state_d;

    gtff_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_trig (
        .clk(clk), .rst(rst), .d({clr_trig, set_trig}), .q(trig_s));

    gtff_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_gate (
        .clk(clk), .rst(rst), .d({clr_gate_n, set_gate_n}), .q(gate_s));

    gtff_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_force (
        .clk(clk), .rst(rst), .d({force_clr, force_set}), .q(force_s));

    gtff_edge_gate #(.PAIRS(PAIRS)) u_set_side (
        .clk(clk), .rst(rst),
        .trig_s(trig_s[PAIRS-1:0]), .gate_s(gate_s[PAIRS-1:0]),
        .accept(set_acc));

    gtff_edge_gate #(.PAIRS(PAIRS)) u_clr_side (
        .clk(clk), .rst(rst),
        .trig_s(trig_s[LVL_W-1:PAIRS]), .gate_s(gate_s[LVL_W-1:PAIRS]),
        .accept(clr_acc));

    always_comb begin
        if (force_s[1])             ev = EV_FORCE_CLR;
        else if (force_s[0])        ev = EV_FORCE_SET;
        else if (set_acc & clr_acc) ev = EV_TOGGLE;
        else if (set_acc)           ev = EV_SET;
        else if (clr_acc)           ev = EV_CLR;
        else                        ev = EV_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                case (ev)
                    EV_SET, EV_TOGGLE, EV_FORCE_SET: state_d = ST_HIGH;
                    default:                         state_d = ST_LOW;
                endcase
            end
            ST_HIGH: begin
                case (ev)
                    EV_CLR, EV_TOGGLE, EV_FORCE_CLR: state_d = ST_LOW;
                    default:                         state_d = ST_HIGH;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        q   = (state_q == ST_HIGH);
        q_n = (state_q == ST_LOW);
    end

    // R10: outputs stay complementary
    assert_complement_R10: assert property (@(posedge clk) disable iff (rst)
        q != q_n);

    // R9: synchronized force-clear always yields a cleared bit
    assert_force_clr_R9: assert property (@(posedge clk) disable iff (rst)
        force_s[1] |=> !q);

    // R8: synchronized force-set alone yields a set bit
    assert_force_set_R8: assert property (@(posedge clk) disable iff (rst)
        (force_s[0] && !force_s[1]) |=> q);

    // R5: without any accepted edge or force the bit holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!set_acc && !clr_acc && force_s == 2'b00) |=> $stable(q));

    // R7: simultaneous accepted edges complement the bit
    assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (set_acc && clr_acc && force_s == 2'b00) |=> (q != $past(q)));
endmodule

// File: tb/gated_trigger_ff_tb.sv
`timescale 1ns/1ps
module gated_trigger_ff_tb;
    localparam int PAIRS = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic [PAIRS-1:0] set_trig, set_gate_n, clr_trig, clr_gate_n;
    logic             force_set, force_clr;
    logic             q, q_n;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];
    event     sample_ev;
    int       n_tests = 0;
    int       n_fail  = 0;
    bit       model   = 1'b0;
    bit       done    = 1'b0;

    always #2.5 clk = ~clk;

    gated_trigger_ff #(.PAIRS(PAIRS), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst),
        .set_trig(set_trig), .set_gate_n(set_gate_n),
        .clr_trig(clr_trig), .clr_gate_n(clr_gate_n),
        .force_set(force_set), .force_clr(force_clr),
        .q(q), .q_n(q_n));

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                n_tests++;
                if (q !== it.exp || q_n !== ~it.exp) begin
                    n_fail++;
                    $display("FAIL %s: q=%b q_n=%b expected q=%b q_n=%b",
                             it.tag, q, q_n, it.exp, ~it.exp);
                end
            end
        end
    end

    task automatic expect_now(input logic e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        -> sample_ev;
        #0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_all();
        set_trig = '1; clr_trig = '1; set_gate_n = '1; clr_gate_n = '1;
    endtask

    // fire a falling edge on one side, then restore (rising edge must be inert)
    task automatic fire(input bit set_side, input int idx, input bit gate_low,
                        input string tag);
        @(negedge clk);
        if (set_side) begin
            set_gate_n[idx] = ~gate_low; set_trig[idx] = 1'b0;
        end else begin
            clr_gate_n[idx] = ~gate_low; clr_trig[idx] = 1'b0;
        end
        if (gate_low) model = set_side;
        settle(3);
        expect_now(model, tag);
        idle_all();
        settle(5);
        expect_now(model, "R5 rising edge/steady level no effect");
    endtask

    initial begin
        rst = 1'b1; force_set = 1'b0; force_clr = 1'b0;
        idle_all();
        repeat (4) @(posedge clk);
        @(negedge clk);
        expect_now(1'b0, "R1 reset value");
        rst = 1'b0;
        settle(6);
        expect_now(1'b0, "R1 no spurious edge after reset");

        // R11 latency
        @(negedge clk);
        set_gate_n[0] = 1'b0; set_trig[0] = 1'b0;
        repeat (2) @(posedge clk); @(negedge clk);
        expect_now(1'b0, "R11 unchanged after two edges");
        settle(1);
        model = 1'b1;
        expect_now(1'b1, "R11 changed after third edge");
        idle_all(); settle(5);

        fire(1'b0, 0, 1'b1, "R3 clear via pair 0");
        fire(1'b1, 1, 1'b1, "R2 set via pair 1");
        fire(1'b0, 1, 1'b1, "R3 clear via pair 1");
        fire(1'b1, 2, 1'b1, "R6 set via extender pair");
        fire(1'b0, 2, 1'b1, "R6 clear via extender pair");
        fire(1'b1, 0, 1'b0, "R4 set edge blocked by high gate");
        fire(1'b1, 0, 1'b1, "R2 set via pair 0");
        fire(1'b0, 0, 1'b0, "R4 clear edge blocked by high gate");

        // R4: gate lowered one cycle after the trigger edge
        @(negedge clk);
        clr_trig[1] = 1'b0;
        @(negedge clk);
        clr_gate_n[1] = 1'b0;
        settle(5);
        expect_now(model, "R4 late gate does not accept edge");
        idle_all(); settle(5);

        // R7 toggle from 1 and from 0
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            set_gate_n[k] = 1'b0; set_trig[k] = 1'b0;
            clr_gate_n[2] = 1'b0; clr_trig[2] = 1'b0;
            model = ~model;
            settle(3);
            expect_now(model, "R7 simultaneous edges toggle");
            idle_all(); settle(5);
        end

        // R8 force_set overrides clear-side edge
        @(negedge clk);
        force_set = 1'b1;
        settle(3);
        clr_gate_n[0] = 1'b0; clr_trig[0] = 1'b0;
        settle(5);
        model = 1'b1;
        expect_now(1'b1, "R8 force_set holds q high over clear edge");
        idle_all();

        // R9 force_clr wins over force_set and set edges
        force_clr = 1'b1;
        settle(3);
        set_gate_n[2] = 1'b0; set_trig[2] = 1'b0;
        settle(5);
        model = 1'b0;
        expect_now(1'b0, "R9 force_clr wins over force_set");
        idle_all();
        force_set = 1'b0; force_clr = 1'b0;
        settle(6);
        expect_now(1'b0, "R9 state holds after forces released");
        expect_now(1'b0, "R10 q_n complement");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule